// File: doc/BRIEF.md
# Front Panel Section Shift-Latch

This block is a write-only bus peripheral that feeds a four-digit seven-segment panel with a colon and a few status LEDs. The panel takes four bytes, called sections, and each bit of a section drives one segment or indicator. The block holds a chain of four byte stages and a 32-bit display latch. Only the latch drives the segment lines.

Software writes single bytes. A write to the shift address pushes the byte into the entry stage of the chain, and every held byte moves one stage further on. A write to the update address does the same push, and on the same clock edge it copies the chain, including the new byte, into the latch. A full panel refresh is therefore three shift writes followed by one update write. The panel changes in one step, and partly loaded data is never visible.

The write decoder produces one of three named commands: `CMD_IDLE` when there is no qualifying write, `CMD_SHIFT` for a write to the shift address, and `CMD_COMMIT` for a write to the update address. These commands act as the block's states. `CMD_IDLE` leaves all state unchanged. `CMD_SHIFT` advances the chain. `CMD_COMMIT` advances the chain and loads the latch. Any write can move the block from one command to another.

Top module: `fpanel_shift_latch`

## Requirements
- R1: A synchronous reset fills every chain stage and the latch with 0xE7. `seg_out` reads 0xE7E7E7E7 in the first cycle after reset.
- R2: A write with `wr_en` high to address `BASE_ADDR` (the shift address) puts `wr_data` into the entry stage. Each held byte moves one stage toward the exit, and the byte in the last stage is discarded. `seg_out` does not change.
- R3: A write with `wr_en` high to address `BASE_ADDR+1` (the update address) shifts the chain in the same way. On that same clock edge, the latch loads the post-shift chain: `seg_out[7:0]` is the byte just written, `seg_out[15:8]` is the byte written before it, and so on up to `seg_out[31:24]`.
- R4: Three shift writes of a, b, c followed by an update write of d give `seg_out` = {a, b, c, d}, so `seg_out[31:24]` = a and `seg_out[7:0]` = d.
- R5: A write with `wr_en` high to any address other than the two decoded ones changes neither the chain nor the latch.
- R6: `seg_out` changes only on the clock edge of an update write. It holds its value across idle cycles and shift writes.
- R7: Data and address presented while `wr_en` is low have no effect on any state.
- R8: The block passes section bytes to the segment lines unchanged. Bits 7, 6, 5, 2, 1 and 0 are active-low and bits 4 and 3 are active-high, so 0x18 lights a whole section and 0xE7 blanks it. The colon pair shares the single bit 7 of one section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | 8 | Byte to push |
| seg_out | output | SECTIONS*8 | Latched segment lines; byte k is the section committed k writes before the newest |

## Verification
The hardest state to see from the ports is the content of the chain, because the chain never drives an output directly. It shows up only after a later update write. The random stimulus mixes shift writes, update writes, writes to unrelated addresses and writes with the strobe low. Every update write then exposes the whole chain, so a corrupted or missed shift from earlier writes appears in `seg_out`. Directed cases cover reset, a full four-write refresh, commits after fewer than three shifts, and the all-lit and blank patterns.

// File: rtl/fpanel_pkg.sv
package fpanel_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_SHIFT  = 2'd1,
        CMD_COMMIT = 2'd2
    } fp_cmd_e;
endpackage

// File: rtl/fp_wr_decode.sv
module fp_wr_decode
    import fpanel_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output fp_cmd_e           cmd,
    output logic              push,
    output logic              load
);
    localparam logic [ADDR_W-1:0] UPD_ADDR = BASE_ADDR + 1'b1;

    always_comb begin
        cmd = CMD_IDLE;
        if (wr_en) begin
            if (wr_addr == BASE_ADDR)
                cmd = CMD_SHIFT;
            else if (wr_addr == UPD_ADDR)
                cmd = CMD_COMMIT;
        end
    end

    always_comb begin
        push = 1'b0;
        load = 1'b0;
        unique case (cmd)
            CMD_IDLE:   begin push = 1'b0; load = 1'b0; end
            CMD_SHIFT:  begin push = 1'b1; load = 1'b0; end
            CMD_COMMIT: begin push = 1'b1; load = 1'b1; end
            default:    begin push = 1'b0; load = 1'b0; end
        endcase
    end

    // R7: no command without the strobe
    assert_no_cmd_without_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (!push && !load));
    // R5: foreign addresses never push
    assert_foreign_addr_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_addr != BASE_ADDR && wr_addr != UPD_ADDR) |-> !push);
    assert_load_implies_push_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> push);
endmodule

// File: rtl/fp_shift_chain.sv
module fp_shift_chain #(
    parameter int               SECTIONS = 4,
    parameter int               BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] FILL    = 8'hE7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [BYTE_W-1:0]            din,
    output logic [SECTIONS*BYTE_W-1:0]   chain_next
);
    logic [BYTE_W-1:0] stage_q [SECTIONS];
    logic [BYTE_W-1:0] stage_d [SECTIONS];

    genvar gi;
    generate
        for (gi = 0; gi < SECTIONS; gi++) begin : g_stage
            if (gi == 0) begin : g_entry
                assign stage_d[gi] = push ? din : stage_q[gi];
            end else begin : g_body
                assign stage_d[gi] = push ? stage_q[gi-1] : stage_q[gi];
            end

            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[gi] <= FILL;
                else
                    stage_q[gi] <= stage_d[gi];
            end

            assign chain_next[gi*BYTE_W +: BYTE_W] = stage_d[gi];

            if (gi > 0) begin : g_chk
                // R2: each held byte moves one stage on
                assert_stage_advance_R2: assert property (@(posedge clk) disable iff (rst)
                    push |=> stage_q[gi] == $past(stage_q[gi-1]));
            end
            assert_stage_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !push |=> $stable(stage_q[gi]));
        end
    endgenerate

    // R2: newest byte enters stage 0
    assert_entry_load_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> stage_q[0] == $past(din));
endmodule

// File: rtl/fp_display_latch.sv
module fp_display_latch #(
    parameter int                W    = 32,
    parameter logic [7:0]        FILL = 8'hE7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int NBYTES = W / 8;
    localparam logic [W-1:0] RST_VAL = {NBYTES{FILL}};

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (load)
            q <= d;
    end

    // R6: output only moves on a commit
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
    // R3: commit captures the post-shift chain
    assert_latch_capture_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d));
    // R1: panel dark after reset
    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> q == RST_VAL);
endmodule

// File: rtl/fpanel_shift_latch.sv
module fpanel_shift_latch
    import fpanel_pkg::*;
#(
    parameter int                SECTIONS  = 4,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h34,
    parameter logic [7:0]        BLANK     = 8'hE7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output logic [SECTIONS*8-1:0]   seg_out
);
    localparam int BYTE_W = 8;
    localparam int PANEL_W = SECTIONS * BYTE_W;

    fp_cmd_e              cmd;
    logic                 push;
    logic                 load;
    logic [PANEL_W-1:0]   chain_next;

    fp_wr_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd),
        .push    (push),
        .load    (load)
    );

    fp_shift_chain #(
        .SECTIONS (SECTIONS),
        .BYTE_W   (BYTE_W),
        .FILL     (BLANK)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .din        (wr_data),
        .chain_next (chain_next)
    );

    fp_display_latch #(
        .W    (PANEL_W),
        .FILL (BLANK)
    ) u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (chain_next),
        .q    (seg_out)
    );

    // R3: the newest byte lands in section 0 on commit
    assert_commit_newest_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_COMMIT) |=> seg_out[7:0] == $past(wr_data));
endmodule

// File: tb/tb_fpanel_shift_latch.sv
module tb_fpanel_shift_latch;
    localparam int SECTIONS = 4;
    localparam int ADDR_W = 8;
    localparam logic [7:0] BASE = 8'h34;
    localparam logic [7:0] UPD  = 8'h35;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [31:0] seg_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] m_chain;
    logic [31:0] m_seg;

    always #4 clk = ~clk;

    fpanel_shift_latch #(
        .SECTIONS (SECTIONS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE),
        .BLANK    (8'hE7)
    ) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .seg_out (seg_out)
    );

    function automatic logic [31:0] shifted(logic [31:0] c, logic [7:0] b);
        return {c[23:0], b};
    endfunction

    task automatic check(string req, logic [31:0] exp);
        checks++;
        if (seg_out !== exp) begin
            errors++;
            $display("FAIL %s seg_out=%h expected=%h", req, seg_out, exp);
        end
    endtask

    task automatic wr(logic en, logic [7:0] a, logic [7:0] d, string req);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        if (en && a == BASE) m_chain = shifted(m_chain, d);
        else if (en && a == UPD) begin
            m_chain = shifted(m_chain, d);
            m_seg = m_chain;
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(req, m_seg);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5021));
        m_chain = 32'hE7E7E7E7;
        m_seg = 32'hE7E7E7E7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", 32'hE7E7E7E7);
        // R1: chain also blank: commit one byte, upper sections stay 0xE7
        wr(1, UPD, 8'h5A, "R1 chain reset");
        // R2 / R6: shifts do not show
        wr(1, BASE, 8'h11, "R2 shift hidden");
        wr(1, BASE, 8'h22, "R6 shift hidden");
        wr(1, BASE, 8'h33, "R2 shift hidden");
        // R4: full refresh
        wr(1, UPD, 8'h44, "R4 full refresh");
        check("R4 order", 32'h11223344);
        // R3: commit after one shift, stale bytes advance
        wr(1, BASE, 8'hA1, "R3 prep");
        wr(1, UPD, 8'hB2, "R3 partial commit");
        check("R3 partial", 32'h3344A1B2);
        // R5: foreign addresses ignored, exposed by a later commit
        wr(1, 8'h33, 8'hFF, "R5 foreign");
        wr(1, 8'h36, 8'hFF, "R5 foreign");
        wr(1, 8'hB4, 8'hFF, "R5 foreign");
        wr(1, UPD, 8'hC3, "R5 chain untouched");
        check("R5 exposed", 32'h44A1B2C3);
        // R7: strobe low ignored
        wr(0, BASE, 8'hEE, "R7 strobe low");
        wr(0, UPD, 8'hEE, "R7 strobe low");
        wr(1, UPD, 8'hD4, "R7 chain untouched");
        check("R7 exposed", 32'hA1B2C3D4);
        // R8: all lit and blank pass through unchanged
        wr(1, BASE, 8'h18, "R8 lit");
        wr(1, BASE, 8'hE7, "R8 blank");
        wr(1, BASE, 8'h18, "R8 lit");
        wr(1, UPD, 8'h98, "R8 colon bit");
        check("R8 pattern", 32'h18E71898);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [7:0] a;
            logic [7:0] d;
            sel = int'($urandom % 4);
            d = 8'($urandom);
            case (sel)
                0: wr(1, BASE, d, "R2 random");
                1: wr(1, UPD, d, "R3 random");
                2: begin
                    a = 8'($urandom);
                    if (a == BASE || a == UPD) a = a ^ 8'h80;
                    wr(1, a, d, "R5 random");
                end
                default: wr(0, (($urandom % 2) != 0) ? BASE : UPD, d, "R7 random");
            endcase
        end
        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_chain = 32'hE7E7E7E7; m_seg = 32'hE7E7E7E7;
        check("R1 rereset", 32'hE7E7E7E7);
        wr(1, UPD, 8'h01, "R1 chain rereset");
        finish_run();
    end
endmodule